// File: doc/BRIEF.md
# Passive-Matrix Row Scan and Drive-Polarity Generator

This block produces the row-scan timing for a 64-row by 128-column passive matrix panel. A phase counter splits every line period into a high half and a low half of the line pulse `lp`. A line counter picks the memory row for each line and starts every frame at a programmable first row, so changing that value scrolls the picture without rewriting memory. A frame marker `flm` flags the first line of each frame. The drive-polarity signal `m_alt` flips either once per frame or after a programmable number of lines.

The block puts the row it needs on `fetch_row` while `lp` is low. An external display memory returns that row on `row_data`, with up to one cycle of read latency. The row is captured when `lp` rises and is presented on `seg_out` when `lp` falls. At that point the block also applies display-off, all-lit and inversion, so the stored picture never changes. `com_idx` gives the common (row driver) position of the line being shown. It counts upward, or downward when reverse scan is selected. The number of lines per frame can be 64, 48, 32 or 16.

Top module: `lcd_scan_gen`

## Requirements
- R1: Line k of a frame (k counted from 0) fetches memory row (start + k) mod 64 on `fetch_row`. `fetch_row` changes only at a falling edge of `lp`, or at the first edge after reset.
- R2: `start_line` is sampled at the falling `lp` edge that ends a frame's last line. The next frame begins at that row. A new value has no effect on the frame in progress.
- R3: `flm` is high for exactly one line period. It rises and falls together with a rising edge of `lp`, and it covers the first line of each frame.
- R4: `row_data` is captured at the rising edge of `lp`. It is driven onto `seg_out` at the next falling edge of `lp`, together with `com_idx`. Neither output changes at any other time.
- R5: `duty_sel` values 0, 1, 2 and 3 give frames of 64, 48, 32 and 16 lines. After any change of `duty_sel`, the next falling edge of `lp` restarts the frame at line 0.
- R6: With `alt_per_line`=0, `m_alt` toggles at the rising `lp` edge that opens each frame's first line. `m_alt` is 0 after reset, so it is 1 during the first frame. `m_alt` changes only at a rising edge of `lp`.
- R7: With `alt_per_line`=1 and `nline_val`=v (v from 1 to 63), `m_alt` toggles every v+1 lines. The count is shared across frame boundaries. It starts from 0 at reset, so the first toggle falls on line v.
- R8: `com_idx` is k for line k when `scan_rev`=0, and 63−k when `scan_rev`=1.
- R9: `invert`=0 passes each row bit to `seg_out` unchanged. `invert`=1 complements every bit.
- R10: `all_lit`=1 drives every bit of `seg_out` to 1, whatever the state of `invert`.
- R11: `disp_on`=0 drives every bit of `seg_out` to 0, overriding `all_lit` and `invert`. Memory contents are unaffected, so normal rows return once `disp_on` is back at 1.
- R12: During reset, `lp`, `flm`, `m_alt`, `seg_out`, `com_idx` and `fetch_row` are all 0. Each line lasts LINE_CYCLES clocks, with `lp` high for the first LINE_CYCLES/2 of them. The first line after reset is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_line | input | 6 | Memory row shown on the first line of a frame (scroll) |
| nline_val | input | 6 | Lines per polarity period minus one, used when `alt_per_line`=1 |
| alt_per_line | input | 1 | 1: toggle polarity every `nline_val`+1 lines; 0: toggle once per frame |
| scan_rev | input | 1 | 1: common index counts down from 63 |
| invert | input | 1 | Complement the segment pattern |
| all_lit | input | 1 | Light every segment |
| disp_on | input | 1 | 0: blank every segment |
| duty_sel | input | 2 | Lines per frame: 0→64, 1→48, 2→32, 3→16 |
| row_data | input | 128 | Row returned by display memory for `fetch_row` |
| lp | output | 1 | Line pulse |
| flm | output | 1 | First-line frame marker |
| m_alt | output | 1 | Drive-polarity signal |
| fetch_row | output | 6 | Memory row requested for the next line |
| com_idx | output | 6 | Common position of the line on `seg_out` |
| seg_out | output | 128 | Processed segment pattern |

## Verification
A corrupted line counter shows up at the next falling edge of `lp`. `fetch_row` then jumps, so the following `seg_out` carries the wrong row pattern and `com_idx` skips a position. A wrong frame length moves `flm`, but only at the end of the current frame, which can be up to 64 line periods later. A fault in the polarity counter changes `m_alt` at the wrong rising edge within v+1 lines, or within one frame. Every row in the bench carries its row number in each byte, so a stale latch, a missed inversion or a wrong scroll offset is seen on the first line it affects.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // Lines per frame for a duty code: each step removes a quarter of the rows.
  function automatic int unsigned frame_lines(input logic [1:0] duty, input int unsigned rows);
    return rows - (rows / 4) * int'(duty);
  endfunction

endpackage

// File: rtl/lcd_phase_gen.sv
module lcd_phase_gen #(
  parameter int LINE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  output logic lp,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = LINE_CYCLES / 2;
  localparam int PW   = $clog2(LINE_CYCLES);

  logic [PW-1:0] ph;

  // The strobes mark the edge on which lp changes.
  assign rise_stb = (ph == PW'(LINE_CYCLES - 1));
  assign fall_stb = (ph == PW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PW'(HALF - 1);
      lp <= 1'b0;
    end else begin
      ph <= rise_stb ? '0 : ph + PW'(1);
      if (rise_stb)      lp <= 1'b1;
      else if (fall_stb) lp <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr
  import lcd_scan_pkg::*;
#(
  parameter int ROWS = 64,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_stb,
  input  logic          fall_stb,
  input  logic [RW-1:0] start_line,
  input  logic [1:0]    duty_sel,
  input  logic          scan_rev,
  output logic [RW-1:0] fetch_row,
  output logic          flm,
  output logic [RW-1:0] com_idx,
  output logic          first_line,
  output logic          seg_upd
);
  logic [RW-1:0] idx;
  logic [1:0]    duty_q;
  logic          restart;
  logic [RW:0]   lines;

  assign lines      = (RW+1)'(frame_lines(duty_q, ROWS));
  assign first_line = (idx == '0);
  assign seg_upd    = fall_stb && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      fetch_row <= '0;
      flm       <= 1'b0;
      com_idx   <= '0;
      duty_q    <= duty_sel;
      restart   <= 1'b1;
    end else begin
      if (rise_stb) flm <= first_line;
      if (fall_stb) begin
        if (!restart)
          com_idx <= scan_rev ? (RW'(ROWS - 1) - idx) : idx;
        if (restart || ({1'b0, idx} == lines - (RW+1)'(1))) begin
          idx       <= '0;
          fetch_row <= start_line;
        end else begin
          idx       <= idx + RW'(1);
          fetch_row <= fetch_row + RW'(1);
        end
        restart <= 1'b0;
      end
      // A duty change arms a restart; it wins over the clear above.
      if (duty_sel != duty_q) begin
        duty_q  <= duty_sel;
        restart <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_alt_gen.sv
module lcd_alt_gen #(
  parameter int ROWS = 64,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_stb,
  input  logic          first_line,
  input  logic          alt_per_line,
  input  logic [RW-1:0] nline_val,
  output logic          m_alt
);
  logic [RW-1:0] nl_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      nl_cnt <= '0;
      m_alt  <= 1'b0;
    end else if (rise_stb) begin
      if (alt_per_line) begin
        if (nl_cnt == nline_val) begin
          nl_cnt <= '0;
          m_alt  <= ~m_alt;
        end else begin
          nl_cnt <= nl_cnt + RW'(1);
        end
      end else begin
        nl_cnt <= '0;
        if (first_line) m_alt <= ~m_alt;
      end
    end
  end
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
  parameter int COLS = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise_stb,
  input  logic            seg_upd,
  input  logic [COLS-1:0] row_data,
  input  logic            invert,
  input  logic            all_lit,
  input  logic            disp_on,
  output logic [COLS-1:0] seg_out
);
  logic [COLS-1:0] row_buf;
  logic [COLS-1:0] shaped;

  // Priority: blanking, then all-lit, then optional inversion.
  always_comb begin
    if (!disp_on)     shaped = '0;
    else if (all_lit) shaped = '1;
    else              shaped = row_buf ^ {COLS{invert}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_buf <= '0;
      seg_out <= '0;
    end else begin
      if (rise_stb) row_buf <= row_data;
      if (seg_upd)  seg_out <= shaped;
    end
  end
endmodule

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen #(
  parameter int ROWS        = 64,
  parameter int COLS        = 128,
  parameter int LINE_CYCLES = 8,
  localparam int RW         = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RW-1:0]   start_line,
  input  logic [RW-1:0]   nline_val,
  input  logic            alt_per_line,
  input  logic            scan_rev,
  input  logic            invert,
  input  logic            all_lit,
  input  logic            disp_on,
  input  logic [1:0]      duty_sel,
  input  logic [COLS-1:0] row_data,
  output logic            lp,
  output logic            flm,
  output logic            m_alt,
  output logic [RW-1:0]   fetch_row,
  output logic [RW-1:0]   com_idx,
  output logic [COLS-1:0] seg_out
);
  logic rise_stb, fall_stb, first_line, seg_upd;

  lcd_phase_gen #(.LINE_CYCLES(LINE_CYCLES)) u_phase (
    .clk(clk), .rst(rst), .lp(lp), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  lcd_line_ctr #(.ROWS(ROWS)) u_line (
    .clk(clk), .rst(rst), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .start_line(start_line), .duty_sel(duty_sel), .scan_rev(scan_rev),
    .fetch_row(fetch_row), .flm(flm), .com_idx(com_idx),
    .first_line(first_line), .seg_upd(seg_upd)
  );

  lcd_alt_gen #(.ROWS(ROWS)) u_alt (
    .clk(clk), .rst(rst), .rise_stb(rise_stb), .first_line(first_line),
    .alt_per_line(alt_per_line), .nline_val(nline_val), .m_alt(m_alt)
  );

  lcd_seg_latch #(.COLS(COLS)) u_seg (
    .clk(clk), .rst(rst), .rise_stb(rise_stb), .seg_upd(seg_upd),
    .row_data(row_data), .invert(invert), .all_lit(all_lit),
    .disp_on(disp_on), .seg_out(seg_out)
  );
endmodule

// File: rtl/lcd_scan_gen_chk.sv
module lcd_scan_gen_chk #(
  parameter int ROWS = 64,
  parameter int COLS = 128,
  localparam int RW  = $clog2(ROWS)
) (
  input logic            clk,
  input logic            rst,
  input logic            lp,
  input logic            flm,
  input logic            m_alt,
  input logic [RW-1:0]   fetch_row,
  input logic [RW-1:0]   com_idx,
  input logic [COLS-1:0] seg_out
);
  // R1: the requested row never moves while lp stays high
  assert_fetch_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (lp && $past(lp)) |-> $stable(fetch_row));

  // R3: the frame marker switches only with a rising line pulse
  assert_flm_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flm) |-> $rose(lp));
  assert_flm_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(flm) |-> $rose(lp));

  // R4: the segment pattern is held while lp stays high
  assert_seg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (lp && $past(lp)) |-> $stable(seg_out));

  // R8: the common index is held while lp stays high
  assert_com_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (lp && $past(lp)) |-> $stable(com_idx));

  // R6 / R7: polarity never changes while lp stays low
  assert_m_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!lp && !$past(lp)) |-> $stable(m_alt));
endmodule

bind lcd_scan_gen lcd_scan_gen_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .lp(lp), .flm(flm), .m_alt(m_alt),
  .fetch_row(fetch_row), .com_idx(com_idx), .seg_out(seg_out)
);

// File: tb/tb_lcd_scan_gen.sv
`timescale 1ns/1ps
module tb_lcd_scan_gen;
  localparam int ROWS = 64;
  localparam int COLS = 128;
  localparam int LC   = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] start_line = '0, nline_val = '0;
  logic alt_per_line = 0, scan_rev = 0, invert = 0, all_lit = 0, disp_on = 1;
  logic [1:0] duty_sel = '0;
  logic [COLS-1:0] row_data;
  logic lp, flm, m_alt;
  logic [5:0] fetch_row, com_idx;
  logic [COLS-1:0] seg_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_scan_gen #(.ROWS(ROWS), .COLS(COLS), .LINE_CYCLES(LC)) dut (
    .clk(clk), .rst(rst), .start_line(start_line), .nline_val(nline_val),
    .alt_per_line(alt_per_line), .scan_rev(scan_rev), .invert(invert),
    .all_lit(all_lit), .disp_on(disp_on), .duty_sel(duty_sel),
    .row_data(row_data), .lp(lp), .flm(flm), .m_alt(m_alt),
    .fetch_row(fetch_row), .com_idx(com_idx), .seg_out(seg_out)
  );

  // Memory model: every byte carries its row number.
  function automatic logic [COLS-1:0] row_of(input logic [5:0] r);
    return {16{2'b10, r}};
  endfunction
  always_comb row_data = row_of(fetch_row);

  task automatic chk(input string req, input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [5:0] sl, input logic [1:0] du, input logic nl,
                          input logic [5:0] nv, input logic sh);
    rst = 1'b1;
    start_line = sl; duty_sel = du; alt_per_line = nl; nline_val = nv; scan_rev = sh;
    invert = 0; all_lit = 0; disp_on = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic next_line();
    @(negedge lp);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 lp in reset", COLS'(lp), '0);
    chk("R12 flm in reset", COLS'(flm), '0);
    chk("R12 m in reset", COLS'(m_alt), '0);
    chk("R12 seg in reset", seg_out, '0);
    chk("R12 com in reset", COLS'(com_idx), '0);
    chk("R12 fetch in reset", COLS'(fetch_row), '0);
  endtask

  task automatic t_lp_shape();
    int hi, lo;
    do_reset(6'd0, 2'd0, 1'b0, 6'd0, 1'b0);
    @(posedge lp);
    hi = 0;
    while (lp) begin @(posedge clk); #1; hi++; end
    lo = 0;
    while (!lp) begin @(posedge clk); #1; lo++; end
    chk("R12 lp high cycles", COLS'(hi), COLS'(LC / 2));
    chk("R12 lp low cycles", COLS'(lo), COLS'(LC - LC / 2));
  endtask

  task automatic t_scroll();
    do_reset(6'd5, 2'd0, 1'b0, 6'd0, 1'b0);
    for (int f = 0; f < 2; f++) begin
      for (int k = 0; k < 64; k++) begin
        next_line();
        chk("R1 row for line", seg_out, row_of(6'(5 + k)));
        chk("R8 com normal", COLS'(com_idx), COLS'(k));
        chk("R3 flm first line only", COLS'(flm), COLS'(k == 0));
        chk("R6 m per frame", COLS'(m_alt), COLS'((f + 1) % 2));
        if (f == 1 && k == 30) start_line = 6'd20;
      end
    end
    for (int k = 0; k < 4; k++) begin
      next_line();
      chk("R2 new start line", seg_out, row_of(6'(20 + k)));
      chk("R12 line index after scroll", COLS'(com_idx), COLS'(k));
    end
  endtask

  task automatic t_duty();
    int n;
    do_reset(6'd7, 2'd1, 1'b0, 6'd0, 1'b0);
    next_line();
    chk("R5 first line marker", COLS'(flm), 1);
    n = 0;
    do begin next_line(); n++; end while (!flm && n < 200);
    chk("R5 48 line frame", COLS'(n), 48);
    duty_sel = 2'd3;
    next_line();
    n = 0;
    while (!flm && n < 200) begin next_line(); n++; end
    chk("R5 restart after duty change", COLS'(n < 3), 1);
    chk("R5 restart row", seg_out, row_of(6'd7));
    n = 0;
    do begin next_line(); n++; end while (!flm && n < 200);
    chk("R5 16 line frame", COLS'(n), 16);
    do_reset(6'd0, 2'd2, 1'b0, 6'd0, 1'b0);
    next_line();
    n = 0;
    do begin next_line(); n++; end while (!flm && n < 200);
    chk("R5 32 line frame", COLS'(n), 32);
  endtask

  task automatic t_nlin();
    do_reset(6'd0, 2'd0, 1'b1, 6'd2, 1'b0);
    for (int j = 0; j < 12; j++) begin
      next_line();
      chk("R7 m every 3 lines", COLS'(m_alt), COLS'(((j + 1) / 3) % 2));
    end
    do_reset(6'd0, 2'd3, 1'b1, 6'd1, 1'b0);
    for (int j = 0; j < 40; j++) begin
      next_line();
      chk("R7 m every 2 lines across frames", COLS'(m_alt), COLS'(((j + 1) / 2) % 2));
    end
  endtask

  task automatic t_shift();
    do_reset(6'd3, 2'd0, 1'b0, 6'd0, 1'b1);
    for (int k = 0; k < 5; k++) begin
      next_line();
      chk("R8 com reversed", COLS'(com_idx), COLS'(63 - k));
      chk("R8 row unchanged by reverse scan", seg_out, row_of(6'(3 + k)));
    end
  endtask

  task automatic t_polarity();
    do_reset(6'd0, 2'd0, 1'b0, 6'd0, 1'b0);
    next_line();
    chk("R9 normal row", seg_out, row_of(6'd0));
    @(posedge lp); #1; invert = 1;
    next_line();
    chk("R9 inverted row", seg_out, ~row_of(6'd1));
    @(posedge lp); #1; all_lit = 1;
    next_line();
    chk("R10 all lit over invert", seg_out, '1);
    @(posedge lp); #1; disp_on = 0;
    next_line();
    chk("R11 display off over all lit", seg_out, '0);
    @(posedge lp); #1; disp_on = 1; all_lit = 0; invert = 0;
    next_line();
    chk("R11 rows return after off", seg_out, row_of(6'd4));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lp_shape();
    t_scroll();
    t_duty();
    t_nlin();
    t_shift();
    t_polarity();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule